// File: doc/BRIEF.md
# Cascadable 4-bit Slice Arithmetic Logic Unit

This block is the combinational datapath core of a microprogrammed processor slice. Each cycle it takes the two read ports of a register file, a direct data word and the contents of a Q register. A 3-bit source code picks an (R, S) operand pair from these inputs, and either operand may be forced to zero. A 3-bit function code then selects one of three arithmetic or five bitwise operations.

The result leaves on `f_out` together with a carry output and three more status flags. A wider word is built by placing several slices side by side. Each slice's `c_out` drives the next slice's `c_in`, the zero outputs of all slices are ANDed, and the negative and overflow flags are taken from the most significant slice. Register storage, the Q register update and destination decoding sit outside this block. The slice width is a parameter with a default of 4.

Top module: `bitslice_alu`

## Requirements
- R1: `src_sel` picks the pair (R,S): 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). Here A is `port_a`, B is `port_b`, D is `d_in` and Q is `q_in`.
- R2: `fn_sel`=0 gives F = R + S + `c_in`, modulo 2^W.
- R3: `fn_sel`=1 gives F = S + ~R + `c_in`, which is S minus R when `c_in`=1.
- R4: `fn_sel`=2 gives F = R + ~S + `c_in`, which is R minus S when `c_in`=1.
- R5: `fn_sel` codes 3 to 7 give R|S, R&S, (~R)&S, R^S and ~(R^S), in that order.
- R6: For codes 0 to 2, `c_out` is the carry out of the top bit of the addition. For codes 3 to 7, `c_out` is 0.
- R7: For codes 0 to 2, `ovf_o` is the XOR of the carries into and out of the top bit. For codes 3 to 7, `ovf_o` is 0.
- R8: `neg_o` equals the top bit of F.
- R9: `zero_o` is 1 exactly when every bit of F is 0.
- R10: A forced-zero operand contributes 0 whatever the values on the unused inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_sel | input | 3 | Operand pair select code |
| fn_sel | input | 3 | Function select code |
| port_a | input | W | Register file read port A |
| port_b | input | W | Register file read port B |
| d_in | input | W | Direct data input |
| q_in | input | W | Q register contents |
| c_in | input | 1 | Carry in from the lower slice |
| f_out | output | W | Function result |
| c_out | output | 1 | Carry out to the upper slice |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Top bit of the result |
| ovf_o | output | 1 | Two's complement overflow |

## Verification
The block holds no state, so a fault in the operand selectors or the carry chain shows on `f_out` and the flags as soon as the inputs settle. No later cycle can hide or delay it. A swapped source code gives a wrong result only when the two mixed-up inputs carry different values. For that reason every source code is swept over independent values of its two operands, under each function and each carry-in. A carry chain broken at a single bit shows only for some operand pairs, so the sweep also covers every R and S combination.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    SRC_AQ = 3'd0,
    SRC_AB = 3'd1,
    SRC_ZQ = 3'd2,
    SRC_ZB = 3'd3,
    SRC_ZA = 3'd4,
    SRC_DA = 3'd5,
    SRC_DQ = 3'd6,
    SRC_DZ = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    FN_ADD   = 3'd0,
    FN_SMR   = 3'd1,
    FN_RMS   = 3'd2,
    FN_OR    = 3'd3,
    FN_AND   = 3'd4,
    FN_NRAND = 3'd5,
    FN_XOR   = 3'd6,
    FN_XNOR  = 3'd7
  } fn_e;

  function automatic logic fn_is_arith(input fn_e fn);
    return (fn == FN_ADD) || (fn == FN_SMR) || (fn == FN_RMS);
  endfunction

  function automatic logic r_is_zero(input src_e s);
    return (s == SRC_ZQ) || (s == SRC_ZB) || (s == SRC_ZA);
  endfunction

endpackage

// File: rtl/alu_operand_mux.sv
module alu_operand_mux import alu_slice_pkg::*; #(
  parameter int W = 4
) (
  input  src_e         src,
  input  logic [W-1:0] a_val,
  input  logic [W-1:0] b_val,
  input  logic [W-1:0] d_val,
  input  logic [W-1:0] q_val,
  output logic [W-1:0] r_val,
  output logic [W-1:0] s_val
);

  always_comb begin
    if (r_is_zero(src)) begin
      r_val = '0;
    end else if (src == SRC_AQ || src == SRC_AB) begin
      r_val = a_val;
    end else begin
      r_val = d_val;
    end
  end

  always_comb begin
    unique case (src)
      SRC_AQ, SRC_ZQ, SRC_DQ: s_val = q_val;
      SRC_AB, SRC_ZB:         s_val = b_val;
      SRC_ZA, SRC_DA:         s_val = a_val;
      default:                s_val = '0;
    endcase
  end

endmodule

// File: rtl/alu_func_core.sv
module alu_func_core import alu_slice_pkg::*; #(
  parameter int W = 4
) (
  input  fn_e          fn,
  input  logic [W-1:0] r_val,
  input  logic [W-1:0] s_val,
  input  logic         cin,
  output logic [W-1:0] f_val,
  output logic [W-1:0] add_x,
  output logic [W-1:0] add_y,
  output logic         arith,
  output logic         carry_top,
  output logic         carry_into_top
);

  logic [W:0]   chain;
  logic [W-1:0] sum;

  assign arith = fn_is_arith(fn);

  always_comb begin
    add_x = r_val;
    add_y = s_val;
    if (fn == FN_SMR) add_x = ~r_val;
    if (fn == FN_RMS) add_y = ~s_val;
  end

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_ripple
    assign sum[i]     = add_x[i] ^ add_y[i] ^ chain[i];
    assign chain[i+1] = (add_x[i] & add_y[i]) | (chain[i] & (add_x[i] ^ add_y[i]));
  end

  assign carry_top      = chain[W];
  assign carry_into_top = chain[W-1];

  always_comb begin
    unique case (fn)
      FN_OR:    f_val = r_val | s_val;
      FN_AND:   f_val = r_val & s_val;
      FN_NRAND: f_val = ~r_val & s_val;
      FN_XOR:   f_val = r_val ^ s_val;
      FN_XNOR:  f_val = ~(r_val ^ s_val);
      default:  f_val = sum;
    endcase
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] f_val,
  input  logic         arith,
  input  logic         carry_top,
  input  logic         carry_into_top,
  output logic         cy,
  output logic         zr,
  output logic         ng,
  output logic         ov
);

  assign cy = arith & carry_top;
  assign ov = arith & (carry_top ^ carry_into_top);
  assign zr = ~|f_val;
  assign ng = f_val[W-1];

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu import alu_slice_pkg::*; #(
  parameter int W = 4
) (
  input  logic [2:0]   src_sel,
  input  logic [2:0]   fn_sel,
  input  logic [W-1:0] port_a,
  input  logic [W-1:0] port_b,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] q_in,
  input  logic         c_in,
  output logic [W-1:0] f_out,
  output logic         c_out,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o
);

  logic [W-1:0] r_op;
  logic [W-1:0] s_op;
  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic         is_arith;
  logic         cy_top;
  logic         cy_msb_in;

  alu_operand_mux #(.W(W)) u_mux (
    .src   (src_e'(src_sel)),
    .a_val (port_a),
    .b_val (port_b),
    .d_val (d_in),
    .q_val (q_in),
    .r_val (r_op),
    .s_val (s_op)
  );

  alu_func_core #(.W(W)) u_core (
    .fn             (fn_e'(fn_sel)),
    .r_val          (r_op),
    .s_val          (s_op),
    .cin            (c_in),
    .f_val          (f_out),
    .add_x          (add_x),
    .add_y          (add_y),
    .arith          (is_arith),
    .carry_top      (cy_top),
    .carry_into_top (cy_msb_in)
  );

  alu_flag_unit #(.W(W)) u_flags (
    .f_val          (f_out),
    .arith          (is_arith),
    .carry_top      (cy_top),
    .carry_into_top (cy_msb_in),
    .cy             (c_out),
    .zr             (zero_o),
    .ng             (neg_o),
    .ov             (ovf_o)
  );

endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
  parameter int W = 4
) (
  input logic [2:0]   src_sel,
  input logic [2:0]   fn_sel,
  input logic         c_in,
  input logic [W-1:0] r_op,
  input logic [W-1:0] s_op,
  input logic [W-1:0] add_x,
  input logic [W-1:0] add_y,
  input logic         is_arith,
  input logic [W-1:0] f_out,
  input logic         c_out,
  input logic         zero_o,
  input logic         neg_o,
  input logic         ovf_o
);

  always_comb begin
    AST_ZERO_NOT_NEG: assert (!(zero_o && neg_o)) else $error("zero and negative together"); // R9
    AST_LOGIC_QUIET: assert (is_arith || (!c_out && !ovf_o)) else $error("flags set by logic op"); // R6
    AST_OVF_SIGN: assert (!(is_arith && ovf_o) ||
                          ((add_x[W-1] == add_y[W-1]) && (f_out[W-1] != add_x[W-1])))
      else $error("overflow without sign change"); // R7
    AST_ADD_WRAP: assert (!(fn_sel == 3'd0 && c_out && c_in == 1'b0) || (f_out < r_op))
      else $error("add carry without wrap"); // R2
    AST_R_FORCED_ZERO: assert (!(src_sel inside {3'd2, 3'd3, 3'd4}) || (r_op == '0))
      else $error("R not zero"); // R10
    AST_S_FORCED_ZERO: assert (!(src_sel == 3'd7) || (s_op == '0))
      else $error("S not zero"); // R10
  end

endmodule

bind bitslice_alu bitslice_alu_chk #(.W(W)) u_chk (
  .src_sel  (src_sel),
  .fn_sel   (fn_sel),
  .c_in     (c_in),
  .r_op     (r_op),
  .s_op     (s_op),
  .add_x    (add_x),
  .add_y    (add_y),
  .is_arith (is_arith),
  .f_out    (f_out),
  .c_out    (c_out),
  .zero_o   (zero_o),
  .neg_o    (neg_o),
  .ovf_o    (ovf_o)
);

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] src_sel, fn_sel;
  logic [3:0] port_a, port_b, d_in, q_in;
  logic       c_in;
  logic [3:0] f_out;
  logic       c_out, zero_o, neg_o, ovf_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bitslice_alu dut (
    .src_sel(src_sel), .fn_sel(fn_sel), .port_a(port_a), .port_b(port_b),
    .d_in(d_in), .q_in(q_in), .c_in(c_in), .f_out(f_out), .c_out(c_out),
    .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive(input int s, input int f, input int a, input int b,
                       input int d, input int q, input int ci);
    src_sel = 3'(s); fn_sel = 3'(f);
    port_a = 4'(a); port_b = 4'(b); d_in = 4'(d); q_in = 4'(q);
    c_in = 1'(ci);
    #1;
  endtask

  // Independent model: returns {F, carry, zero, negative, overflow}
  function automatic int model(int s, int f, int a, int b, int d, int q, int ci);
    int r, sv, x, y, tot, res, cy, ov;
    case (s)
      0, 1:    r = a;
      2, 3, 4: r = 0;
      default: r = d;
    endcase
    case (s)
      0, 2, 6: sv = q;
      1, 3:    sv = b;
      4, 5:    sv = a;
      default: sv = 0;
    endcase
    cy = 0; ov = 0;
    if (f <= 2) begin
      x = (f == 1) ? 15 - r : r;
      y = (f == 2) ? 15 - sv : sv;
      tot = x + y + ci;
      res = tot % 16;
      cy = (tot > 15) ? 1 : 0;
      ov = (((x >= 8) == (y >= 8)) && ((res >= 8) != (x >= 8))) ? 1 : 0;
    end else begin
      case (f)
        3: res = r | sv;
        4: res = r & sv;
        5: res = (15 - r) & sv;
        6: res = r ^ sv;
        default: res = 15 - (r ^ sv);
      endcase
    end
    return (res << 4) | (cy << 3) | ((res == 0 ? 1 : 0) << 2) |
           ((res >= 8 ? 1 : 0) << 1) | ov;
  endfunction

  task automatic t_idle();
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R9 idle zero", zero_o, 1);
    chk("R2 idle F", f_out, 0);
    chk("R6 idle carry", c_out, 0);
    chk("R7 idle ovf", ovf_o, 0);
  endtask

  task automatic t_sources();
    int exp_or[8] = '{5, 3, 4, 2, 1, 9, 12, 8};
    for (int s = 0; s < 8; s++) begin
      drive(s, 3, 1, 2, 8, 4, 0);
      chk((s inside {2, 3, 4, 7}) ? "R10 forced zero" : "R1 source pair", f_out, exp_or[s]);
    end
  endtask

  task automatic t_add();
    drive(1, 0, 7, 8, 0, 0, 1);
    chk("R2 add wrap F", f_out, 0);
    chk("R6 add carry", c_out, 1);
    chk("R9 add zero", zero_o, 1);
    chk("R7 add no ovf", ovf_o, 0);
    drive(1, 0, 7, 1, 0, 0, 0);
    chk("R2 add F", f_out, 8);
    chk("R7 add ovf", ovf_o, 1);
    chk("R8 add neg", neg_o, 1);
    chk("R6 add no carry", c_out, 0);
  endtask

  task automatic t_sub();
    drive(1, 1, 3, 5, 0, 0, 1);
    chk("R3 S-R F", f_out, 2);
    chk("R6 S-R carry", c_out, 1);
    drive(1, 1, 5, 3, 0, 0, 1);
    chk("R3 S-R neg F", f_out, 14);
    chk("R8 S-R neg", neg_o, 1);
    chk("R6 S-R borrow", c_out, 0);
    drive(1, 2, 8, 1, 0, 0, 1);
    chk("R4 R-S F", f_out, 7);
    chk("R7 R-S ovf", ovf_o, 1);
    chk("R6 R-S carry", c_out, 1);
  endtask

  task automatic t_logic();
    int exp_f[5] = '{14, 8, 2, 6, 9};
    for (int f = 3; f < 8; f++) begin
      drive(1, f, 12, 10, 0, 0, 1);
      chk("R5 logic F", f_out, exp_f[f-3]);
      chk("R6 logic carry", c_out, 0);
      chk("R7 logic ovf", ovf_o, 0);
    end
  endtask

  task automatic t_sweep();
    string tags[8] = '{"R2", "R3", "R4", "R5", "R5", "R5", "R5", "R5"};
    for (int s = 0; s < 8; s++)
      for (int f = 0; f < 8; f++)
        for (int ci = 0; ci < 2; ci++)
          for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
              for (int z = 0; z < 16; z++) begin
                int got;
                drive(s, f, x, z ^ x, y, z, ci);
                got = (int'(f_out) << 4) | (int'(c_out) << 3) | (int'(zero_o) << 2) |
                      (int'(neg_o) << 1) | int'(ovf_o);
                chk(tags[f], got, model(s, f, x, z ^ x, y, z, ci));
              end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog got %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #25 rst_n = 1'b1;
    t_idle();
    t_sources();
    t_add();
    t_sub();
    t_logic();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule